// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block moves 36-bit words from a write port on `wr_clk` to a read port on `rd_clk`. The two clocks may be unrelated or may be the same clock. The write pointer and the read pointer each cross to the other side as gray code through a two-flop synchroniser. The write side computes its ready and almost-full flags against the synchronised read pointer. The read side computes its data-available and almost-empty flags against the synchronised write pointer.

The block has two read-timing modes, chosen while full reset is high. In standard mode, `rd_avail` means the store is not empty, and a word appears on `rd_data` one read clock after an accepted read. In fall-through mode, the oldest word is loaded onto `rd_data` without any strobe, `rd_avail` marks it valid, and `rd_en` consumes it.

The almost-empty and almost-full thresholds come from a preset chosen at reset, or they are loaded after reset. They can be loaded as two parallel words on the write bus or shifted in bit by bit. A full reset clears the stored data, the mode and the thresholds. A partial reset clears only the stored data.

The configuration machine runs in the write domain and has these states:
- `CF_PAR_AE`: moves to `CF_PAR_AF` on `wr_en`.
- `CF_PAR_AF`: moves to `CF_READY` on `wr_en`.
- `CF_SHIFT`: moves to `CF_READY` on the last `ser_en` bit.
- `CF_READY`: holds.

Full reset enters `CF_READY` when `cfg_preset` is a preset. For the load code it enters `CF_SHIFT` when `cfg_serial` is 1, and `CF_PAR_AE` otherwise.

The read machine has these states:
- `RD_STD`: standard timing; it holds.
- `RD_FW_EMPTY`: moves to `RD_FW_VALID` when the store is not empty, fetching a word.
- `RD_FW_VALID`: on `rd_en`, either refetches or returns to `RD_FW_EMPTY` when the store is empty.

Full reset picks `RD_STD` or `RD_FW_EMPTY` from `cfg_fwft`. Partial reset sends a fall-through state to `RD_FW_EMPTY`.

Top module: `dc_flag_fifo`

## Requirements
- R1: After full reset with a preset selected, `rd_avail` is 0, `wr_avail` is 1, `almost_empty` is 1 and `almost_full` is 0.
- R2: In standard mode (`cfg_fwft`=0), words leave in the order they were written. An accepted read (`rd_en`=1 with `rd_avail`=1) presents its word on `rd_data` after the next `rd_clk` edge.
- R3: `wr_avail` is 0 while DEPTH words are stored. A write while `wr_avail` is 0 stores nothing and moves no pointer.
- R4: A read while no word is available is ignored and leaves the read pointer unchanged.
- R5: In fall-through mode (`cfg_fwft`=1), the oldest word appears on `rd_data` with no read strobe, and `rd_avail` rises when it is valid. With identical clocks, this happens three edges after the edge that wrote it. The word holds until `rd_en` consumes it.
- R6: `almost_empty` is 1 when the stored word count is at or below the almost-empty threshold. In fall-through mode the word held on `rd_data` counts.
- R7: `almost_full` is 1 when the free space (DEPTH minus count) is at or below the almost-full threshold.
- R8: `cfg_preset` values 0, 1 and 2 set both thresholds to 8, 16 and 64 respectively.
- R9: With `cfg_preset`=3 and `cfg_serial`=0, the first two `wr_en` cycles after reset load the almost-empty threshold and then the almost-full threshold from `wr_data[log2(DEPTH)-1:0]`. These words are not stored, and `wr_avail` stays 0 until both are loaded.
- R10: With `cfg_preset`=3 and `cfg_serial`=1, 2·log2(DEPTH) bits are shifted in on `ser_din` while `ser_en` is 1. The almost-empty threshold comes first, most significant bit first, then the almost-full threshold. `wr_avail` stays 0 until the last bit.
- R11: A partial reset empties the FIFO but keeps the timing mode and both thresholds.
- R12: A write and a read on the same edge of identical clocks both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| full_rst | input | 1 | Synchronous full reset, active high, held across edges of both clocks |
| part_rst | input | 1 | Synchronous partial reset, active high, held across edges of both clocks |
| cfg_fwft | input | 1 | Timing mode sampled during full reset: 1 selects fall-through |
| cfg_preset | input | 2 | Threshold preset sampled during full reset: 0/1/2 select 8/16/64, 3 selects loading |
| cfg_serial | input | 1 | With preset code 3: 1 selects serial loading, 0 selects parallel loading |
| wr_en | input | 1 | Write strobe; during parallel loading it strobes a threshold word |
| wr_data | input | 36 | Write data |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_din | input | 1 | Serial threshold data bit |
| wr_avail | output | 1 | Ready to accept a write (not-full in standard mode, input-ready in fall-through mode) |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 36 | Read data |
| rd_avail | output | 1 | Not empty in standard mode; output word valid in fall-through mode |
| almost_empty | output | 1 | Word count at or below the almost-empty threshold |

## Verification
The bench builds the block with DEPTH=256 and drives both clock pins from one clock. With identical clocks the crossing latency is exact, so flag transitions can be sampled on a known cycle. DEPTH=256 gives an 8-bit threshold field, which makes serial loading 16 bits long. It also keeps filling to the full boundary, and to the almost-full edge under every threshold, short enough to do several times per run. Every preset, both load paths, both timing modes and the partial reset are each taken through their flag boundaries.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
    localparam int DATA_W = 36;

    typedef enum logic [1:0] {
        CF_PAR_AE,
        CF_PAR_AF,
        CF_SHIFT,
        CF_READY
    } cfg_state_t;

    typedef enum logic [1:0] {
        RD_STD,
        RD_FW_EMPTY,
        RD_FW_VALID
    } rd_state_t;

    // Preset threshold for a reset-time selection code.
    function automatic int unsigned preset_offset(input logic [1:0] sel);
        int unsigned v;
        unique case (sel)
            2'd0:    v = 8;
            2'd1:    v = 16;
            default: v = 64;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_cfg.sv
module dcf_cfg
    import dcf_pkg::*;
#(
    parameter int OW = 8
) (
    input  logic          clk,
    input  logic          full_rst,
    input  logic [1:0]    cfg_preset,
    input  logic          cfg_serial,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_word,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off,
    output logic          ready
);
    localparam int NBITS = 2 * OW;
    localparam int CW    = $clog2(NBITS);

    cfg_state_t    st, st_nx;
    logic [CW-1:0] bit_cnt;
    logic [OW-1:0] ae_q, af_q;

    // State register
    always_ff @(posedge clk) begin
        if (full_rst) begin
            if (cfg_preset != 2'd3) st <= CF_READY;
            else if (cfg_serial)    st <= CF_SHIFT;
            else                    st <= CF_PAR_AE;
        end else begin
            st <= st_nx;
        end
    end

    // Transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            CF_PAR_AE: if (wr_en) st_nx = CF_PAR_AF;
            CF_PAR_AF: if (wr_en) st_nx = CF_READY;
            CF_SHIFT:  if (ser_en && bit_cnt == CW'(NBITS - 1)) st_nx = CF_READY;
            CF_READY:  st_nx = CF_READY;
            default:   st_nx = CF_READY;
        endcase
    end

    // Threshold registers
    always_ff @(posedge clk) begin
        if (full_rst) begin
            bit_cnt <= '0;
            if (cfg_preset != 2'd3) begin
                ae_q <= OW'(preset_offset(cfg_preset));
                af_q <= OW'(preset_offset(cfg_preset));
            end else begin
                ae_q <= '0;
                af_q <= '0;
            end
        end else begin
            unique case (st)
                CF_PAR_AE: if (wr_en) ae_q <= wr_word;
                CF_PAR_AF: if (wr_en) af_q <= wr_word;
                CF_SHIFT: begin
                    if (ser_en) begin
                        {ae_q, af_q} <= {ae_q[OW-2:0], af_q, ser_din};
                        bit_cnt      <= bit_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        ready  = (st == CF_READY);
        ae_off = ae_q;
        af_off = af_q;
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          wr_en,
    input  logic [PW-1:0] rd_gray_s,
    input  logic [AW-1:0] af_off,
    output logic [PW-1:0] wr_bin,
    output logic [PW-1:0] wr_gray,
    output logic [PW-1:0] level,
    output logic          push,
    output logic          wr_avail,
    output logic          almost_full
);
    logic [PW-1:0] rd_bin_s;
    logic [PW-1:0] free_cnt;
    logic [PW-1:0] wr_bin_nx;
    logic          full;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        rd_bin_s    = g2b(rd_gray_s);
        level       = wr_bin - rd_bin_s;
        full        = (level == PW'(DEPTH));
        wr_avail    = enable && !full;
        push        = wr_en && wr_avail;
        free_cnt    = PW'(DEPTH) - level;
        almost_full = (free_cnt <= {1'b0, af_off});
        wr_bin_nx   = wr_bin + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (push) begin
            wr_bin  <= wr_bin_nx;
            wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH),
    parameter int PW    = AW + 1
) (
    input  logic              clk,
    input  logic              full_rst,
    input  logic              part_rst,
    input  logic              cfg_fwft,
    input  logic              rd_en,
    input  logic [PW-1:0]     wr_gray_s,
    input  logic [AW-1:0]     ae_off,
    input  logic [DATA_W-1:0] mem_q,
    output logic [PW-1:0]     rd_bin,
    output logic [PW-1:0]     rd_gray,
    output logic              mem_empty,
    output logic              fwft_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic              almost_empty
);
    rd_state_t     st, st_nx;
    logic [PW-1:0] wr_bin_s;
    logic [PW-1:0] mem_level;
    logic [PW-1:0] total;
    logic [PW-1:0] rd_bin_nx;
    logic          fetch;

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        wr_bin_s  = g2b(wr_gray_s);
        mem_level = wr_bin_s - rd_bin;
        mem_empty = (mem_level == '0);
        rd_bin_nx = rd_bin + 1'b1;
    end

    // State register
    always_ff @(posedge clk) begin
        if (full_rst)      st <= cfg_fwft ? RD_FW_EMPTY : RD_STD;
        else if (part_rst) st <= (st == RD_STD) ? RD_STD : RD_FW_EMPTY;
        else               st <= st_nx;
    end

    // Transitions and fetch decision
    always_comb begin
        st_nx = st;
        fetch = 1'b0;
        unique case (st)
            RD_STD: fetch = rd_en && !mem_empty;
            RD_FW_EMPTY: begin
                if (!mem_empty) begin
                    fetch = 1'b1;
                    st_nx = RD_FW_VALID;
                end
            end
            RD_FW_VALID: begin
                if (rd_en) begin
                    if (!mem_empty) fetch = 1'b1;
                    else            st_nx = RD_FW_EMPTY;
                end
            end
            default: st_nx = RD_STD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (full_rst || part_rst) begin
            rd_bin  <= '0;
            rd_gray <= '0;
            rd_data <= '0;
        end else if (fetch) begin
            rd_bin  <= rd_bin_nx;
            rd_gray <= rd_bin_nx ^ (rd_bin_nx >> 1);
            rd_data <= mem_q;
        end
    end

    // Outputs
    always_comb begin
        fwft_mode    = (st != RD_STD);
        rd_avail     = (st == RD_STD) ? !mem_empty : (st == RD_FW_VALID);
        total        = mem_level + {{(PW-1){1'b0}}, (st == RD_FW_VALID)};
        almost_empty = (total <= {1'b0, ae_off});
    end
endmodule

// File: rtl/dc_flag_fifo.sv
module dc_flag_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              full_rst,
    input  logic              part_rst,
    input  logic              cfg_fwft,
    input  logic [1:0]        cfg_preset,
    input  logic              cfg_serial,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ser_en,
    input  logic              ser_din,
    output logic              wr_avail,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_avail,
    output logic              almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic              data_rst;
    logic [AW-1:0]     ae_off, af_off;
    logic              cfg_ready;
    logic [PW-1:0]     wr_bin, wr_gray, wr_level, rd_gray_s;
    logic [PW-1:0]     rd_bin, rd_gray, wr_gray_s;
    logic              push, mem_empty, fwft_mode;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] mem [DEPTH];

    assign data_rst = full_rst || part_rst;

    dcf_cfg #(.OW(AW)) u_cfg (
        .clk        (wr_clk),
        .full_rst   (full_rst),
        .cfg_preset (cfg_preset),
        .cfg_serial (cfg_serial),
        .wr_en      (wr_en),
        .wr_word    (wr_data[AW-1:0]),
        .ser_en     (ser_en),
        .ser_din    (ser_din),
        .ae_off     (ae_off),
        .af_off     (af_off),
        .ready      (cfg_ready)
    );

    dcf_sync #(.W(PW)) u_rd2wr (
        .clk (wr_clk), .rst (data_rst), .d (rd_gray), .q (rd_gray_s)
    );

    dcf_sync #(.W(PW)) u_wr2rd (
        .clk (rd_clk), .rst (data_rst), .d (wr_gray), .q (wr_gray_s)
    );

    dcf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk         (wr_clk),
        .rst         (data_rst),
        .enable      (cfg_ready),
        .wr_en       (wr_en),
        .rd_gray_s   (rd_gray_s),
        .af_off      (af_off),
        .wr_bin      (wr_bin),
        .wr_gray     (wr_gray),
        .level       (wr_level),
        .push        (push),
        .wr_avail    (wr_avail),
        .almost_full (almost_full)
    );

    always_ff @(posedge wr_clk) begin
        if (push) mem[wr_bin[AW-1:0]] <= wr_data;
    end

    assign mem_q = mem[rd_bin[AW-1:0]];

    dcf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_rd (
        .clk          (rd_clk),
        .full_rst     (full_rst),
        .part_rst     (part_rst),
        .cfg_fwft     (cfg_fwft),
        .rd_en        (rd_en),
        .wr_gray_s    (wr_gray_s),
        .ae_off       (ae_off),
        .mem_q        (mem_q),
        .rd_bin       (rd_bin),
        .rd_gray      (rd_gray),
        .mem_empty    (mem_empty),
        .fwft_mode    (fwft_mode),
        .rd_data      (rd_data),
        .rd_avail     (rd_avail),
        .almost_empty (almost_empty)
    );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk
    import dcf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int PW    = $clog2(DEPTH) + 1
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              full_rst,
    input logic              part_rst,
    input logic              wr_avail,
    input logic [PW-1:0]     wr_bin,
    input logic [PW-1:0]     wr_gray,
    input logic [PW-1:0]     wr_level,
    input logic [PW-1:0]     rd_bin,
    input logic              mem_empty,
    input logic              fwft_mode,
    input logic              rd_avail,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data
);
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (full_rst || part_rst)
        !wr_avail |=> $stable(wr_bin))
        else $error("write pointer moved while not ready");

    p_level_cap_r3: assert property (@(posedge wr_clk) disable iff (full_rst || part_rst)
        wr_level <= PW'(DEPTH))
        else $error("stored level above depth");

    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (full_rst || part_rst)
        mem_empty |=> $stable(rd_bin))
        else $error("read pointer moved while empty");

    p_fwft_hold_r5: assert property (@(posedge rd_clk) disable iff (full_rst || part_rst)
        (fwft_mode && rd_avail && !rd_en) |=> (rd_avail && $stable(rd_data)))
        else $error("fall-through word not held");

    p_gray_step_r12: assert property (@(posedge wr_clk) disable iff (full_rst || part_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1)
        else $error("gray pointer changed more than one bit");
endmodule

bind dc_flag_fifo dcf_chk #(.DEPTH(DEPTH)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .full_rst  (full_rst),
    .part_rst  (part_rst),
    .wr_avail  (wr_avail),
    .wr_bin    (wr_bin),
    .wr_gray   (wr_gray),
    .wr_level  (wr_level),
    .rd_bin    (rd_bin),
    .mem_empty (mem_empty),
    .fwft_mode (fwft_mode),
    .rd_avail  (rd_avail),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
);

// File: tb/dc_flag_fifo_bench.sv
module dc_flag_fifo_bench;
    localparam int DEPTH = 256;
    localparam int OW    = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        full_rst = 1'b1, part_rst = 1'b0;
    logic        cfg_fwft = 1'b0, cfg_serial = 1'b0;
    logic [1:0]  cfg_preset = 2'd0;
    logic        wr_en = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic [35:0] wr_data = '0;
    logic        rd_en;
    logic        wr_avail, almost_full, rd_avail, almost_empty;
    logic [35:0] rd_data;

    int          n_chk = 0, n_fail = 0;
    logic [35:0] exp_q[$];
    bit          rd_go = 0, rd_force = 0, fw = 0, rd_pend = 0, done = 0;
    logic [35:0] stamp = 36'h0_A000_0000;

    always #2 clk = ~clk;

    dc_flag_fifo #(.DEPTH(DEPTH)) u_dc_flag_fifo (
        .wr_clk(clk), .rd_clk(clk), .full_rst(full_rst), .part_rst(part_rst),
        .cfg_fwft(cfg_fwft), .cfg_preset(cfg_preset), .cfg_serial(cfg_serial),
        .wr_en(wr_en), .wr_data(wr_data), .ser_en(ser_en), .ser_din(ser_din),
        .wr_avail(wr_avail), .almost_full(almost_full), .rd_en(rd_en),
        .rd_data(rd_data), .rd_avail(rd_avail), .almost_empty(almost_empty)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: drives rd_en and pops the scoreboard as words come out
    always @(negedge clk) begin
        if (!fw) begin
            if (rd_pend) begin
                if (exp_q.size() == 0) check("R4 no unexpected word", 64'd1, 64'd0);
                else                   check("R2 standard order", rd_data, exp_q.pop_front());
            end
            rd_pend = rd_go && rd_avail;
            rd_en   = rd_force || (rd_go && rd_avail);
        end else begin
            rd_pend = 0;
            if (rd_go && rd_avail) begin
                if (exp_q.size() == 0) check("R4 no unexpected word", 64'd1, 64'd0);
                else                   check("R5 fall-through order", rd_data, exp_q.pop_front());
                rd_en = 1'b1;
            end else begin
                rd_en = rd_force;
            end
        end
    end

    // Driver: one accepted write, expected word queued
    task automatic push(input logic [35:0] d);
        while (!wr_avail) @(negedge clk);
        wr_en = 1'b1; wr_data = d; exp_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic push_n(input int n);
        for (int i = 0; i < n; i++) begin
            stamp = stamp + 36'h1_0003;
            push(stamp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drain();
        rd_go = 1;
        while (exp_q.size() != 0) @(negedge clk);
        rd_go = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_full_reset(input bit f, input logic [1:0] p, input bit s);
        full_rst = 1'b1; cfg_fwft = f; cfg_preset = p; cfg_serial = s; fw = f;
        exp_q.delete();
        repeat (3) @(negedge clk);
        full_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_part_reset();
        part_rst = 1'b1;
        exp_q.delete();
        repeat (2) @(negedge clk);
        part_rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        logic [2*OW-1:0] sbits;
        repeat (2) @(negedge clk);
        // Reset state, preset 8, standard mode
        do_full_reset(0, 2'd0, 0);
        check("R1 rd_avail after reset", rd_avail, 0);
        check("R1 wr_avail after reset", wr_avail, 1);
        check("R1 almost_empty after reset", almost_empty, 1);
        check("R1 almost_full after reset", almost_full, 0);

        // R6 / R8: preset 8 almost-empty boundary
        push_n(8); settle();
        check("R6 R8 ae at 8 words", almost_empty, 1);
        check("R2 rd_avail with data", rd_avail, 1);
        push_n(1); settle();
        check("R6 R8 ae at 9 words", almost_empty, 0);
        drain();
        check("R2 empty after drain", rd_avail, 0);
        check("R6 ae after drain", almost_empty, 1);

        // R4: reads while empty are ignored
        rd_force = 1; repeat (3) @(negedge clk); rd_force = 0;
        push_n(2); settle();
        check("R4 level intact after empty reads", rd_avail, 1);
        drain();
        check("R4 empty after drain", rd_avail, 0);

        // R7 / R3: almost-full and full, preset 8
        push_n(DEPTH - 9); settle();
        check("R7 af at free 9", almost_full, 0);
        push_n(1); settle();
        check("R7 af at free 8", almost_full, 1);
        push_n(8); settle();
        check("R3 wr_avail when full", wr_avail, 0);
        wr_en = 1'b1; wr_data = 36'hF_FFFF_FFFF;
        repeat (2) @(negedge clk);
        wr_en = 1'b0; settle();
        check("R3 still full after ignored writes", wr_avail, 0);
        drain();
        check("R3 no extra word stored", rd_avail, 0);

        // R12: concurrent read and write on the same edge
        rd_go = 1;
        push_n(40);
        drain();
        check("R12 empty after streaming", rd_avail, 0);

        // R8: preset 64
        do_full_reset(0, 2'd2, 0);
        push_n(64); settle();
        check("R8 ae at 64 words", almost_empty, 1);
        push_n(1); settle();
        check("R8 ae at 65 words", almost_empty, 0);
        check("R8 af at free 191", almost_full, 0);
        drain();

        // R11: partial reset keeps threshold 16
        do_full_reset(0, 2'd1, 0);
        push_n(5); settle();
        do_part_reset();
        check("R11 empty after partial reset", rd_avail, 0);
        check("R11 wr_avail after partial reset", wr_avail, 1);
        push_n(10); settle();
        check("R11 threshold 16 kept at 10 words", almost_empty, 1);
        push_n(7); settle();
        check("R11 ae at 17 words", almost_empty, 0);
        drain();

        // R5: fall-through mode
        do_full_reset(1, 2'd0, 0);
        stamp = stamp + 36'h7;
        push(stamp);
        check("R5 not valid right after write", rd_avail, 0);
        repeat (2) @(negedge clk);
        check("R5 not valid two edges later", rd_avail, 0);
        @(negedge clk);
        check("R5 valid without strobe", rd_avail, 1);
        check("R5 first word on bus", rd_data, stamp);
        push_n(7); settle();
        check("R6 fall-through ae at 8 words", almost_empty, 1);
        push_n(1); settle();
        check("R6 fall-through ae at 9 words", almost_empty, 0);
        drain();
        check("R5 invalid after drain", rd_avail, 0);
        do_part_reset();
        stamp = stamp + 36'h9;
        push(stamp);
        repeat (3) @(negedge clk);
        check("R11 fall-through mode kept", rd_avail, 1);
        check("R11 fall-through word", rd_data, stamp);
        rd_go = 1;
        push_n(30);
        drain();

        // R9: parallel load ae=5, af=3
        do_full_reset(0, 2'd3, 0);
        check("R9 wr_avail low while loading", wr_avail, 0);
        wr_en = 1'b1; wr_data = 36'd5;
        @(negedge clk);
        check("R9 wr_avail low after first word", wr_avail, 0);
        wr_data = 36'd3;
        @(negedge clk);
        wr_en = 1'b0;
        check("R9 wr_avail after load", wr_avail, 1);
        settle();
        check("R9 load words not stored", rd_avail, 0);
        push_n(5); settle();
        check("R9 ae at 5 words", almost_empty, 1);
        push_n(1); settle();
        check("R9 ae at 6 words", almost_empty, 0);
        push_n(DEPTH - 4 - 6); settle();
        check("R9 af at free 4", almost_full, 0);
        push_n(1); settle();
        check("R9 af at free 3", almost_full, 1);
        drain();

        // R10: serial load ae=2, af=4
        do_full_reset(0, 2'd3, 1);
        sbits = {OW'(2), OW'(4)};
        for (int i = 2 * OW - 1; i >= 0; i--) begin
            if (i == 0) check("R10 wr_avail low before last bit", wr_avail, 0);
            ser_en = 1'b1; ser_din = sbits[i];
            @(negedge clk);
        end
        ser_en = 1'b0;
        check("R10 wr_avail after shift", wr_avail, 1);
        push_n(2); settle();
        check("R10 ae at 2 words", almost_empty, 1);
        push_n(1); settle();
        check("R10 ae at 3 words", almost_empty, 0);
        push_n(DEPTH - 5 - 3); settle();
        check("R10 af at free 5", almost_full, 0);
        push_n(1); settle();
        check("R10 af at free 4", almost_full, 1);
        drain();

        done = 1;
        finish_run();
    end
endmodule